// File: doc/BRIEF.md
# Peripheral Set/Clear Register Bank

This block is the software-facing register bank of one peripheral on a 32-bit synchronous peripheral bus. It holds four kinds of register: a command register, a mode register, a status vector and an interrupt mask.

- **Command register.** Write-only. Each bit written as one produces a single-cycle pulse toward the peripheral core.
- **Mode register.** An ordinary read/write configuration word.
- **Status vector and interrupt mask.** Neither is written directly. Each has a companion pair of write-only addresses: writing ones to the first sets the matching bits, and writing ones to the second clears them. Software can therefore change any bit with one store and never needs a read-modify-write sequence. The current value of each vector is read at its own address.

The interrupt-source output goes high whenever any status bit and its mask bit are both set. It feeds a separate interrupt controller.

The bank decodes a 16 KB window. Every access is treated as a full word: the two low address bits and the size field do not affect the result. Read data is combinational and is zero unless the read strobe is high.

Top module: `periph_regbank`

## Requirements
- R1: While `rst_n` is low at a clock edge, the mode register, the status vector and the interrupt mask clear to 0, and `cmd_pulse` and `irq_src` are 0 after that edge.
- R2: `addr[1:0]` and `size` (0 byte, 1 half-word, 2 word, 3 reserved) never change behaviour. Every access reaches the full 32-bit register at `addr` with its two low bits forced to zero, and writes take all of `wdata`.
- R3: A write to the status-set address (offset 0x10) sets every status bit whose `wdata` bit is one, from the next clock edge. Zero bits leave their status bit unchanged.
- R4: A write to the status-clear address (offset 0x14) clears every status bit whose `wdata` bit is one. Zero bits leave their status bit unchanged. If a set and a clear of the same bit arrive together, the clear wins.
- R5: A write to the command address (offset 0x00) drives `cmd_pulse` to `wdata[CMD_W-1:0]` for exactly the one cycle after the write edge. Outside that cycle `cmd_pulse` is 0.
- R6: The mode register (offset 0x04) is written with the full `wdata` and read back unchanged. It changes only on a write to its own address.
- R7: The interrupt mask is set through offset 0x20 and cleared through offset 0x24, each bit by a one in `wdata`. Its value is read at offset 0x28.
- R8: `irq_src` is 1 exactly when some bit is set in both the status vector and the mask. It follows the register values in the same cycle they change.
- R9: Reads of the write-only addresses (0x00, 0x10, 0x14, 0x20, 0x24) return 0.
- R10: Reads of any address in the window that maps to no register return 0. Writes to such an address change no output and no readable register.
- R11: Status (offset 0x18) and mask reads return 0 in bits `STAT_W` and above. `wdata` bits above `STAT_W-1` written to the set and clear addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (14) | Byte address inside the 16 KB window |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| rd_en | input | 1 | Read strobe |
| size | input | 2 | Access size code; every size is carried out as a word access |
| rdata | output | 32 | Combinational read data, 0 when `rd_en` is low |
| mode_out | output | MODE_W (32) | Current mode register value |
| cmd_pulse | output | CMD_W (8) | One-cycle command pulses |
| stat_out | output | STAT_W (8) | Current status vector |
| irq_src | output | 1 | Interrupt source: OR of status AND mask |

## Verification
The bench targets several corner cases, each of which a specific fault would expose:
- **Narrow accesses at unaligned byte addresses.** A decoder that honoured `addr[1:0]` would miss the mode register or hit the wrong one.
- **Zero and all-ones writes to the set and clear addresses.** An implementation that wrote the data straight into the register would lose status bits on a zero write. One that ignored the width limit would let high `wdata` bits leak.
- **Mask changes against a fixed status, and status changes against a fixed mask.** A gate missing the AND, or using the wrong vector, would raise or hold `irq_src` wrongly.
- **Back-to-back and isolated command writes, and writes to unmapped offsets.** A pulse stretched by a cycle would fail here, as would a decoder that aliased holes onto real registers.

// File: rtl/regbank_pkg.sv
// Shared definitions for the peripheral register bank.
// Assumes a 32-bit data bus; offsets are word indices inside the window.
package regbank_pkg;

    // Access size codes carried on the bus; all are serviced as word accesses.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Word indices (byte offset / 4) of the registers.
    localparam int WIX_CMD   = 0;   // 0x00 command, write-only
    localparam int WIX_MODE  = 1;   // 0x04 mode, read/write
    localparam int WIX_SSET  = 4;   // 0x10 status set, write-only
    localparam int WIX_SCLR  = 5;   // 0x14 status clear, write-only
    localparam int WIX_STAT  = 6;   // 0x18 status, read-only
    localparam int WIX_ISET  = 8;   // 0x20 mask set, write-only
    localparam int WIX_ICLR  = 9;   // 0x24 mask clear, write-only
    localparam int WIX_IMASK = 10;  // 0x28 mask, read-only

    // One-hot register select produced by the decoder.
    typedef struct packed {
        logic cmd;
        logic mode;
        logic sset;
        logic sclr;
        logic stat;
        logic iset;
        logic iclr;
        logic imask;
    } reg_sel_t;

endpackage

// File: rtl/regbank_decode.sv
// Address decoder: turns a word index into a one-hot register select.
// Assumes the caller already dropped the byte-lane bits; holes select nothing.
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int WIDX_W = 12
) (
    input  logic [WIDX_W-1:0] widx,
    output reg_sel_t          sel
);

    // Compare the word index against every register offset.
    always_comb begin
        sel       = '0;
        sel.cmd   = (widx == WIX_CMD[WIDX_W-1:0]);
        sel.mode  = (widx == WIX_MODE[WIDX_W-1:0]);
        sel.sset  = (widx == WIX_SSET[WIDX_W-1:0]);
        sel.sclr  = (widx == WIX_SCLR[WIDX_W-1:0]);
        sel.stat  = (widx == WIX_STAT[WIDX_W-1:0]);
        sel.iset  = (widx == WIX_ISET[WIDX_W-1:0]);
        sel.iclr  = (widx == WIX_ICLR[WIDX_W-1:0]);
        sel.imask = (widx == WIX_IMASK[WIDX_W-1:0]);
    end

endmodule

// File: rtl/setclr_bits.sv
// Bit vector changed only by set and clear strobes; a clear beats a set
// of the same bit. Assumes strobes are already qualified by the write.
module setclr_bits #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] q
);

    // Apply sets, then clears, on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q | set_v) & ~clr_v;
    end

    // R4: any bit strobed for clear is zero afterwards.
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v != '0) |=> ((q & $past(clr_v)) == '0));

    // R3: a bit set without a clear is one afterwards.
    a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_v & ~clr_v) != '0) |=> ((q & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v)));

    // R3 / R4: with no strobe the vector holds.
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v == '0 && clr_v == '0) |=> $stable(q));

endmodule

// File: rtl/cmd_pulser.sv
// Turns a command write into a single-cycle pulse per bit written as one.
// Assumes at most one bus write per cycle.
module cmd_pulser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [W-1:0] bits,
    output logic [W-1:0] pulse
);

    // Register the written ones for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    pulse <= '0;
        else if (fire) pulse <= bits;
        else           pulse <= '0;
    end

    // R5: a pulse only follows a command write.
    a_r5_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse != '0) |-> $past(fire));

    // R5: no write on the last edge means no pulse now.
    a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (pulse == '0));

endmodule

// File: rtl/periph_regbank.sv
// Register bank of one peripheral: command pulses, mode word, status and
// interrupt mask with set/clear addresses, and the interrupt source.
// Assumes one access per cycle; every access is serviced as an aligned word.
module periph_regbank
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int MODE_W = 32,
    parameter int STAT_W = 8,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        size,
    output logic [31:0]       rdata,
    output logic [MODE_W-1:0] mode_out,
    output logic [CMD_W-1:0]  cmd_pulse,
    output logic [STAT_W-1:0] stat_out,
    output logic              irq_src
);

    localparam int WIDX_W = ADDR_W - 2;

    reg_sel_t          sel;
    logic [MODE_W-1:0] mode_q;
    logic [STAT_W-1:0] stat_q, mask_q;
    logic [STAT_W-1:0] sset_v, sclr_v, iset_v, iclr_v;
    logic [31:0]       rd_mux;

    // Byte-lane bits are dropped: every access lands on a whole word.
    regbank_decode #(.WIDX_W(WIDX_W)) u_dec (
        .widx (addr[ADDR_W-1:2]),
        .sel  (sel)
    );

    // Qualify the set and clear strobes with the write.
    always_comb begin
        sset_v = (wr_en && sel.sset) ? wdata[STAT_W-1:0] : '0;
        sclr_v = (wr_en && sel.sclr) ? wdata[STAT_W-1:0] : '0;
        iset_v = (wr_en && sel.iset) ? wdata[STAT_W-1:0] : '0;
        iclr_v = (wr_en && sel.iclr) ? wdata[STAT_W-1:0] : '0;
    end

    setclr_bits #(.W(STAT_W)) u_stat (
        .clk (clk), .rst_n (rst_n), .set_v (sset_v), .clr_v (sclr_v), .q (stat_q)
    );

    setclr_bits #(.W(STAT_W)) u_mask (
        .clk (clk), .rst_n (rst_n), .set_v (iset_v), .clr_v (iclr_v), .q (mask_q)
    );

    cmd_pulser #(.W(CMD_W)) u_cmd (
        .clk (clk), .rst_n (rst_n), .fire (wr_en && sel.cmd),
        .bits (wdata[CMD_W-1:0]), .pulse (cmd_pulse)
    );

    // Mode register: full-word write at its own address only.
    always_ff @(posedge clk) begin
        if (!rst_n)                mode_q <= '0;
        else if (wr_en && sel.mode) mode_q <= wdata[MODE_W-1:0];
    end

    // Read mux: readable registers only; write-only and holes give zero.
    always_comb begin
        rd_mux = '0;
        if (sel.mode)  rd_mux[MODE_W-1:0] = mode_q;
        if (sel.stat)  rd_mux[STAT_W-1:0] = stat_q;
        if (sel.imask) rd_mux[STAT_W-1:0] = mask_q;
    end

    assign rdata    = rd_en ? rd_mux : '0;
    assign mode_out = mode_q;
    assign stat_out = stat_q;
    assign irq_src  = |(stat_q & mask_q);

    // R2: the access-size and lane bits must be known on any access.
    a_r2_access_known: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) |-> !$isunknown({size, addr}));

    // R8: an interrupt needs both a status bit and a mask bit.
    a_r8_irq_needs_stat: assert property (@(posedge clk) disable iff (!rst_n)
        irq_src |-> (stat_out != '0 && mask_q != '0));

    // R6: mode moves only on a write to its address.
    a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel.mode) |=> $stable(mode_out));

    // R9: write-only addresses read as zero.
    a_r9_wo_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel.cmd || sel.sset || sel.sclr || sel.iset || sel.iclr)) |-> (rdata == '0));

    // R10: holes in the window read as zero.
    a_r10_hole_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == '0) |-> (rdata == '0));

endmodule

// File: tb/sim_periph_regbank.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on every clock and compared
// against the ports after each edge.
module sim_periph_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  size = 2'd2;
    logic [31:0] rdata, mode_out;
    logic [7:0]  cmd_pulse, stat_out;
    logic        irq_src;

    int vectors = 0, miscompares = 0;
    bit done = 0;

    // Reference state.
    logic [31:0] m_mode = '0;
    logic [7:0]  m_stat = '0, m_mask = '0, m_cmd = '0;

    always #2.5 clk = ~clk;

    periph_regbank u0 (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wdata (wdata),
        .wr_en (wr_en), .rd_en (rd_en), .size (size), .rdata (rdata),
        .mode_out (mode_out), .cmd_pulse (cmd_pulse), .stat_out (stat_out),
        .irq_src (irq_src)
    );

    function automatic logic [31:0] model_read(input logic [13:0] a);
        case (a & 14'h3FFC)
            14'h004: return m_mode;
            14'h018: return {24'h0, m_stat};
            14'h028: return {24'h0, m_mask};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_update(input logic w, input logic [13:0] a, input logic [31:0] d);
        m_cmd = '0;
        if (w) begin
            case (a & 14'h3FFC)
                14'h000: m_cmd  = d[7:0];
                14'h004: m_mode = d;
                14'h010: m_stat = m_stat | d[7:0];
                14'h014: m_stat = m_stat & ~d[7:0];
                14'h020: m_mask = m_mask | d[7:0];
                14'h024: m_mask = m_mask & ~d[7:0];
                default: ;
            endcase
        end
    endtask

    task automatic check_state(input string tag);
        logic [48:0] got, exp;
        got = {mode_out, stat_out, cmd_pulse, irq_src};
        exp = {m_mode, m_stat, m_cmd, |(m_stat & m_mask)};
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s state: got mode=%h stat=%h cmd=%h irq=%b exp mode=%h stat=%h cmd=%h irq=%b",
                     tag, mode_out, stat_out, cmd_pulse, irq_src,
                     m_mode, m_stat, m_cmd, |(m_stat & m_mask));
        end
    endtask

    task automatic check_read(input string tag, input logic [31:0] exp);
        vectors++;
        if (rdata !== exp) begin
            miscompares++;
            $display("FAIL %s rdata: got %h exp %h", tag, rdata, exp);
        end
    endtask

    // One bus cycle, driven at the falling edge, checked after the rising edge.
    task automatic step(input logic w, input logic r, input logic [13:0] a,
                        input logic [31:0] d, input logic [1:0] sz, input string tag);
        wr_en = w; rd_en = r; addr = a; wdata = d; size = sz;
        #1;
        if (r) check_read(tag, model_read(a));
        @(posedge clk);
        model_update(w, a, d);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check_state(tag);
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b0, a, d, 2'd2, tag);
    endtask

    task automatic rd(input logic [13:0] a, input string tag);
        step(1'b0, 1'b1, a, 32'h0, 2'd2, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_state("R1");
        rst_n = 1'b1;
        foreach (model_read_addrs[i]) rd(model_read_addrs[i], "R1");

        // R6: full-word mode write and readback.
        wr(14'h004, 32'hA5A5_1234, "R6");
        rd(14'h004, "R6");
        // R2: half-word write at an unaligned lane still updates the whole word.
        step(1'b1, 1'b0, 14'h006, 32'h0000_BEEF, 2'd1, "R2");
        step(1'b0, 1'b1, 14'h007, 32'h0, 2'd0, "R2");
        step(1'b1, 1'b0, 14'h005, 32'hFFFF_0001, 2'd3, "R2");
        rd(14'h004, "R2");

        // R3 / R4: set and clear with several patterns.
        wr(14'h010, 32'h0F, "R3");
        wr(14'h010, 32'h30, "R3");
        wr(14'h010, 32'h00, "R3");
        wr(14'h014, 32'h05, "R4");
        wr(14'h014, 32'h00, "R4");
        rd(14'h018, "R4");
        // R11: high data bits have no effect, high read bits are zero.
        wr(14'h010, 32'hFFFF_FF00, "R11");
        wr(14'h014, 32'hFFFF_FF00, "R11");
        rd(14'h018, "R11");

        // R7 / R8: mask against fixed status and status against fixed mask.
        wr(14'h020, 32'h80, "R8");
        wr(14'h020, 32'h02, "R8");
        rd(14'h028, "R7");
        wr(14'h024, 32'h02, "R8");
        wr(14'h010, 32'h80, "R8");
        wr(14'h014, 32'h80, "R8");
        wr(14'h024, 32'hFF, "R7");
        rd(14'h028, "R7");

        // R5: isolated and back-to-back command writes.
        wr(14'h000, 32'h81, "R5");
        step(1'b0, 1'b0, 14'h000, 32'h0, 2'd2, "R5");
        wr(14'h000, 32'h01, "R5");
        wr(14'h002, 32'hF0, "R5");
        wr(14'h000, 32'h00, "R5");

        // R9: write-only addresses read zero.
        rd(14'h000, "R9"); rd(14'h010, "R9"); rd(14'h014, "R9");
        rd(14'h020, "R9"); rd(14'h024, "R9");

        // R10: holes read zero and ignore writes.
        wr(14'h02C, 32'hFFFF_FFFF, "R10");
        wr(14'h100, 32'hFFFF_FFFF, "R10");
        wr(14'h3FFC, 32'hFFFF_FFFF, "R10");
        rd(14'h02C, "R10"); rd(14'h3FFF, "R10");
        rd(14'h004, "R10"); rd(14'h018, "R10"); rd(14'h028, "R10");

        // Mixed random traffic over registers and holes, all requirements.
        for (int i = 0; i < 400; i++) begin
            logic [13:0] a;
            case ($urandom_range(0, 9))
                0: a = 14'h000; 1: a = 14'h004; 2: a = 14'h010; 3: a = 14'h014;
                4: a = 14'h018; 5: a = 14'h020; 6: a = 14'h024; 7: a = 14'h028;
                8: a = 14'h030; default: a = 14'($urandom);
            endcase
            a = a | 14'($urandom_range(0, 3));
            step(1'($urandom), 1'($urandom), a, $urandom, 2'($urandom), "R2_R8_mix");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    logic [13:0] model_read_addrs [8] = '{14'h000, 14'h004, 14'h010, 14'h014,
                                          14'h018, 14'h020, 14'h024, 14'h028};

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule